// File: doc/BRIEF.md
# Three-Stage Forwarding Integer Pipeline

This block is a small 32-bit integer core with three pipeline stages. The first stage presents the program counter to a synchronous instruction memory. The second stage takes the returned word, reads both source registers and runs the ALU in the same cycle. The third stage writes the result into the register file. The core has one port for instruction memory and a separate port for data memory. Only the load and store instructions use the data port. Every other instruction works from register to register and finishes in one cycle.

Each instruction is one fixed-format word, so the register fields can be read before the opcode has been decoded. When an instruction writes a register, the result is forwarded straight to the instruction behind it, so dependent instructions run back to back. Branches and the jump-and-link instruction are delayed: the instruction that follows them in memory always executes. Loads and stores take two cycles. In the second cycle the fetch stage repeats its address, and a loaded value reaches the next user through the same forwarding path.

The register write stage is visible on three output pins. An integrating block can use them as a retirement trace.

Top module: `tri_stage_core`

## Requirements
- R1: A synchronous active-high reset sets the fetch address to BOOT_ADDR (default 0) and clears the pipeline to no-ops. While reset is held and in the first cycle after it, no register write and no data write occur. Fetch addresses after reset go 0, then 4.
- R2: Instruction word layout: opcode in bits 31:26, destination in 25:21, first source in 20:16, second source in 15:11, and a signed immediate in 10:0. Opcodes: 1 ADD, 2 SUB, 3 AND, 4 OR, 5 XOR, 6 SLT (signed compare, result 1 or 0), 7 SLL, 8 SRL, 9 ADDI, 10 LD, 11 ST, 12 BEQ, 13 BNE, 14 JAL.
- R3: Each register-to-register operation, and ADDI, writes its result in the cycle after it executes. The shift amount is bits 4:0 of the second source.
- R4: An instruction that reads the register written by the instruction just before it gets the new value with no bubble, so the two register writes land in consecutive cycles.
- R5: Register 0 always reads as zero. A write to it produces no register write, and it is never forwarded.
- R6: LD and ST use indexed addressing: the byte address is the first source plus the immediate. A store drives the data port, with the second source as data, in its first cycle. Every LD or ST leaves a one-cycle gap behind it, during which the fetch address holds.
- R7: A load writes its destination two cycles after it executes. The instruction that follows it receives the loaded value by forwarding.
- R8: BEQ and BNE compare the two sources. The taken target is the delay-slot address plus four times the immediate. The delay-slot instruction always executes, and a taken branch adds no bubble.
- R9: JAL always jumps, using the same target rule as the branches. It writes to its destination the address just past its delay slot.
- R10: An opcode outside the list in R2 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Fetch byte address |
| imem_rdata | input | 32 | Instruction word, one cycle after the address |
| dmem_addr | output | 32 | Data byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data, one cycle after the address |
| rf_we | output | 1 | Register write this cycle |
| rf_wa | output | 5 | Register being written |
| rf_wd | output | 32 | Value being written |

## Verification
The bench builds the core with BOOT_ADDR left at 0. Its 64-word program array therefore starts at the first fetch, and a self-branch near the top of that array parks the core once the program is done. The program covers the corner cases in sequence:
- a chain of dependent ALU operations;
- a write to register 0 followed by a read of it;
- a store, then a load from the same address, then a use of the loaded value;
- a taken branch, a not-taken branch, and a jump-and-link, each with a delay slot that does work;
- an unknown opcode spinning in the final delay slot.

The cycle stamps of the register writes expose the forwarding, stall and delay-slot timing.

// File: rtl/tri_stage_core.sv
module tri_stage_core #(
  parameter logic [31:0] BOOT_ADDR = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  output logic        dmem_re,
  input  logic [31:0] dmem_rdata,
  output logic        rf_we,
  output logic [4:0]  rf_wa,
  output logic [31:0] rf_wd
);
  localparam logic [5:0] OP_ADD = 6'd1, OP_SUB = 6'd2, OP_AND = 6'd3, OP_OR = 6'd4,
                         OP_XOR = 6'd5, OP_SLT = 6'd6, OP_SLL = 6'd7, OP_SRL = 6'd8,
                         OP_ADDI = 6'd9, OP_LD = 6'd10, OP_ST = 6'd11, OP_BEQ = 6'd12,
                         OP_BNE = 6'd13, OP_JAL = 6'd14;

  logic [31:0] pc, ex_pc;
  logic        ex_vld;
  logic [31:0] rf [0:31];
  logic        w_vld, ld_pend;
  logic [4:0]  w_rd, ld_rd;
  logic [31:0] w_dat;

  wire [5:0]  op   = imem_rdata[31:26];
  wire [4:0]  rd   = imem_rdata[25:21];
  wire [4:0]  rs1  = imem_rdata[20:16];
  wire [4:0]  rs2  = imem_rdata[15:11];
  wire [31:0] simm = {{21{imem_rdata[10]}}, imem_rdata[10:0]};

  wire [31:0] a = (rs1 == 5'd0) ? 32'd0 : (w_vld && w_rd == rs1) ? w_dat : rf[rs1];
  wire [31:0] b = (rs2 == 5'd0) ? 32'd0 : (w_vld && w_rd == rs2) ? w_dat : rf[rs2];

  logic [31:0] res;
  logic        wr, taken;

  always_comb begin
    res = 32'd0;
    wr = 1'b1;
    taken = 1'b0;
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_SLT:  res = {31'd0, $signed(a) < $signed(b)};
      OP_SLL:  res = a << b[4:0];
      OP_SRL:  res = a >> b[4:0];
      OP_ADDI: res = a + simm;
      OP_JAL:  begin res = ex_pc + 32'd8; taken = 1'b1; end
      OP_BEQ:  begin wr = 1'b0; taken = (a == b); end
      OP_BNE:  begin wr = 1'b0; taken = (a != b); end
      default: wr = 1'b0;
    endcase
  end

  wire is_mem = (op == OP_LD) || (op == OP_ST);
  wire stall  = ex_vld && is_mem;
  wire [31:0] target = ex_pc + 32'd4 + (simm << 2);

  assign imem_addr  = pc;
  assign dmem_addr  = a + simm;
  assign dmem_wdata = b;
  assign dmem_we    = ex_vld && (op == OP_ST);
  assign dmem_re    = ex_vld && (op == OP_LD);
  assign rf_we      = w_vld;
  assign rf_wa      = w_rd;
  assign rf_wd      = w_dat;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= BOOT_ADDR;
      ex_pc   <= BOOT_ADDR;
      ex_vld  <= 1'b0;
      w_vld   <= 1'b0;
      w_rd    <= 5'd0;
      w_dat   <= 32'd0;
      ld_pend <= 1'b0;
      ld_rd   <= 5'd0;
    end else begin
      pc      <= stall ? pc : (ex_vld && taken) ? target : pc + 32'd4;
      ex_pc   <= pc;
      ex_vld  <= !stall;
      ld_pend <= dmem_re && (rd != 5'd0);
      ld_rd   <= rd;
      if (ld_pend) begin
        w_vld <= 1'b1;
        w_rd  <= ld_rd;
        w_dat <= dmem_rdata;
      end else begin
        w_vld <= ex_vld && wr && (rd != 5'd0);
        w_rd  <= rd;
        w_dat <= res;
      end
    end
  end

  always_ff @(posedge clk)
    if (!rst && w_vld) rf[w_rd] <= w_dat;

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (imem_addr == BOOT_ADDR && !rf_we && !dmem_we));  // R1
  AST_ZERO_BASE: assert property (@(posedge clk) disable iff (rst) (ex_vld && is_mem && rs1 == 5'd0) |-> dmem_addr == simm);  // R5
  AST_MEM_BUBBLE: assert property (@(posedge clk) disable iff (rst) stall |=> !ex_vld);  // R6
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst) stall |=> $stable(imem_addr));  // R6
  AST_ALU_NEXT: assert property (@(posedge clk) disable iff (rst) (ex_vld && wr && !is_mem && rd != 5'd0) |=> (rf_we && rf_wa == $past(rd)));  // R3
  AST_LOAD_LATE: assert property (@(posedge clk) disable iff (rst) (dmem_re && rd != 5'd0) |=> ##1 (rf_we && rf_wa == $past(rd, 2)));  // R7
  AST_DELAY_SLOT: assert property (@(posedge clk) disable iff (rst) (ex_vld && taken) |=> (ex_vld && ex_pc == $past(ex_pc) + 32'd4 && imem_addr == $past(ex_pc) + 32'd4 + ($past(simm) << 2)));  // R8
endmodule

// File: tb/test_tri_stage_core.sv
`timescale 1ns/1ps
module test_tri_stage_core;
  logic clk = 1'b0, rst = 1'b1;
  logic [31:0] imem_addr, imem_q, dmem_addr, dmem_wdata, dmem_q, rf_wd;
  logic dmem_we, dmem_re, rf_we;
  logic [4:0] rf_wa;

  always #2.5 clk = ~clk;

  tri_stage_core i_tri_stage_core (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_q),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we), .dmem_re(dmem_re),
    .dmem_rdata(dmem_q), .rf_we(rf_we), .rf_wa(rf_wa), .rf_wd(rf_wd));

  logic [31:0] imem [0:63];
  logic [31:0] dmem [0:63];

  always @(posedge clk) begin
    imem_q <= imem[imem_addr[7:2]];
    dmem_q <= dmem[dmem_addr[7:2]];
    if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
  end

  int n_chk = 0, n_fail = 0, cyc = 0, zero_wr = 0;
  bit live = 0, done = 0;
  int wcyc [0:31];
  int wcnt [0:31];
  logic [31:0] wval [0:31];
  logic [4:0]  q_rd [$];
  logic [31:0] q_rv [$];
  string       q_tag [$];
  logic [31:0] q_sa [$];
  logic [31:0] q_sd [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] rd,
                                      input logic [4:0] s1, input logic [4:0] s2, input int imm);
    return {op, rd, s1, s2, imm[10:0]};
  endfunction

  always @(negedge clk) if (live) begin
    if (rf_we) begin
      if (rf_wa == 5'd0) zero_wr++;
      wcyc[rf_wa] = cyc;
      wcnt[rf_wa]++;
      wval[rf_wa] = rf_wd;
      if (q_rd.size() == 0) chk(0, "R10 unexpected write", {27'd0, rf_wa}, 32'd0);
      else begin
        chk(rf_wa == q_rd[0], {q_tag[0], " dest"}, {27'd0, rf_wa}, {27'd0, q_rd[0]});
        chk(rf_wd == q_rv[0], {q_tag[0], " value"}, rf_wd, q_rv[0]);
        void'(q_rd.pop_front()); void'(q_rv.pop_front()); void'(q_tag.pop_front());
      end
    end
    if (dmem_we) begin
      if (q_sa.size() == 0) chk(0, "R6 unexpected store", dmem_addr, 32'd0);
      else begin
        chk(dmem_addr == q_sa[0], "R6 store address", dmem_addr, q_sa[0]);
        chk(dmem_wdata == q_sd[0], "R6 store data", dmem_wdata, q_sd[0]);
        void'(q_sa.pop_front()); void'(q_sd.pop_front());
      end
    end
  end

  task automatic run_model();
    logic [31:0] r [0:31];
    logic [31:0] mm [0:63];
    logic [31:0] pc = 32'd0, npc = 32'd4, nn, ins, x, y, s, v;
    logic [5:0] op;
    logic [4:0] rd;
    bit w, t;
    string tag;
    for (int i = 0; i < 32; i++) r[i] = 32'd0;
    for (int i = 0; i < 64; i++) mm[i] = 32'd0;
    for (int step = 0; step < 120; step++) begin
      ins = imem[pc[7:2]];
      op = ins[31:26]; rd = ins[25:21];
      x = r[ins[20:16]]; y = r[ins[15:11]];
      s = {{21{ins[10]}}, ins[10:0]};
      w = 1; t = 0; v = 32'd0; tag = "R3";
      case (op)
        6'd1: v = x + y;
        6'd2: v = x - y;
        6'd3: v = x & y;
        6'd4: v = x | y;
        6'd5: v = x ^ y;
        6'd6: v = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
        6'd7: v = x << y[4:0];
        6'd8: v = x >> y[4:0];
        6'd9: v = x + s;
        6'd10: begin v = mm[(x + s) >> 2]; tag = "R7"; end
        6'd11: begin w = 0; mm[(x + s) >> 2] = y; q_sa.push_back(x + s); q_sd.push_back(y); end
        6'd12: begin w = 0; t = (x == y); end
        6'd13: begin w = 0; t = (x != y); end
        6'd14: begin v = pc + 32'd8; t = 1; tag = "R9"; end
        default: w = 0;
      endcase
      if (w && rd != 5'd0) begin
        r[rd] = v; q_rd.push_back(rd); q_rv.push_back(v); q_tag.push_back(tag);
      end
      nn = t ? pc + 32'd4 + (s << 2) : npc + 32'd4;
      pc = npc; npc = nn;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "watchdog expired", 32'd0, 32'd1);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin imem[i] = 32'd0; dmem[i] = 32'd0; end
    for (int i = 0; i < 32; i++) begin wcyc[i] = 0; wcnt[i] = 0; wval[i] = 32'd0; end
    imem[0]  = enc(9, 1, 0, 0, 5);
    imem[1]  = enc(9, 2, 1, 0, 7);
    imem[2]  = enc(1, 3, 1, 2, 0);
    imem[3]  = enc(2, 4, 3, 1, 0);
    imem[4]  = enc(9, 0, 0, 0, 9);
    imem[5]  = enc(1, 5, 0, 4, 0);
    imem[6]  = enc(11, 0, 0, 3, 8);
    imem[7]  = enc(10, 6, 0, 0, 8);
    imem[8]  = enc(1, 7, 6, 6, 0);
    imem[9]  = enc(5, 8, 7, 1, 0);
    imem[10] = enc(3, 9, 8, 2, 0);
    imem[11] = enc(4, 10, 9, 1, 0);
    imem[12] = enc(6, 11, 0, 1, 0);
    imem[13] = enc(9, 12, 0, 0, -3);
    imem[14] = enc(6, 13, 12, 0, 0);
    imem[15] = enc(7, 14, 1, 11, 0);
    imem[16] = enc(8, 15, 12, 1, 0);
    imem[17] = enc(12, 0, 1, 1, 2);
    imem[18] = enc(9, 16, 0, 0, 1);
    imem[19] = enc(9, 17, 0, 0, 99);
    imem[20] = enc(13, 0, 1, 1, 5);
    imem[21] = enc(9, 18, 0, 0, 2);
    imem[22] = enc(9, 19, 0, 0, 3);
    imem[23] = enc(14, 20, 0, 0, 1);
    imem[24] = enc(9, 21, 0, 0, 4);
    imem[25] = enc(11, 0, 0, 20, 12);
    imem[26] = enc(10, 22, 0, 0, 12);
    imem[27] = enc(11, 0, 0, 22, 16);
    imem[28] = enc(9, 31, 22, 0, 1);
    imem[29] = enc(12, 0, 0, 0, -1);
    imem[30] = enc(6'h3F, 1, 1, 1, 3);
    run_model();

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(imem_addr == 32'd0, "R1 fetch address in reset", imem_addr, 32'd0);
    chk(!rf_we && !dmem_we && !dmem_re, "R1 quiet in reset", {29'd0, rf_we, dmem_we, dmem_re}, 32'd0);
    rst = 1'b0;
    live = 1;
    chk(imem_addr == 32'd0, "R1 first fetch", imem_addr, 32'd0);
    @(negedge clk);
    chk(imem_addr == 32'd4, "R1 second fetch", imem_addr, 32'd4);
    chk(!rf_we && !dmem_we, "R1 no write in first cycle", {30'd0, rf_we, dmem_we}, 32'd0);
    repeat (150) @(negedge clk);

    chk(wval[3] == 32'd17, "R2 fields decoded", wval[3], 32'd17);
    chk(wval[15] == 32'h07FF_FFFF, "R3 logical right shift", wval[15], 32'h07FF_FFFF);
    chk(wval[13] == 32'd1, "R3 signed compare", wval[13], 32'd1);
    chk(wval[14] == 32'd10, "R3 left shift", wval[14], 32'd10);
    chk(wcyc[2] - wcyc[1] == 1, "R4 no bubble first source", wcyc[2] - wcyc[1], 32'd1);
    chk(wcyc[3] - wcyc[2] == 1, "R4 no bubble second source", wcyc[3] - wcyc[2], 32'd1);
    chk(wval[5] == 32'd12, "R5 zero register read", wval[5], 32'd12);
    chk(zero_wr == 0, "R5 write to zero register", zero_wr, 32'd0);
    chk(wcyc[6] - wcyc[5] == 4, "R6 two-cycle store and load", wcyc[6] - wcyc[5], 32'd4);
    chk(dmem[2] == 32'd17, "R6 stored word", dmem[2], 32'd17);
    chk(dmem[4] == 32'd100, "R6 store of loaded value", dmem[4], 32'd100);
    chk(wcyc[7] - wcyc[6] == 1, "R7 load forwarded", wcyc[7] - wcyc[6], 32'd1);
    chk(wval[7] == 32'd34, "R7 load-use value", wval[7], 32'd34);
    chk(wval[16] == 32'd1, "R8 delay slot executed", wval[16], 32'd1);
    chk(wcnt[17] == 0, "R8 skipped instruction", wcnt[17], 32'd0);
    chk(wcyc[18] - wcyc[16] == 2, "R8 taken branch no bubble", wcyc[18] - wcyc[16], 32'd2);
    chk(wval[19] == 32'd3, "R8 not-taken falls through", wval[19], 32'd3);
    chk(wval[20] == 32'd100, "R9 link address", wval[20], 32'd100);
    chk(wval[21] == 32'd4, "R9 delay slot executed", wval[21], 32'd4);
    chk(wcnt[1] == 1, "R10 unknown opcode no write", wcnt[1], 32'd1);
    chk(q_rd.size() == 0 && q_sa.size() == 0, "R10 all expected events seen", q_rd.size() + q_sa.size(), 32'd0);
    if (!done) begin
      done = 1;
      finish_run();
    end
  end
endmodule